// File: doc/BRIEF.md
# I2C Target Message Framing Engine

This block turns the per-byte event strobes of a byte-level I2C target into whole messages. A write transaction carries a message: the first data byte is a kind byte, the second is a length byte, and the payload follows. At the stop, the engine checks the number of bytes it captured against the length implied by the header. A correct message is published on a valid/ready byte stream. A wrong one is dropped with an error pulse.

A write of the single command byte 0x01, followed by a repeated-start read, opens a transmit phase. The engine then drives the bytes of an externally held outgoing message one per read request. If nothing is queued, it drives a three-byte filler instead. A request line tells the bus side that an outgoing message is waiting. Protocol faults are reported as one-cycle pulses on separate pins.

The output stream follows valid/ready rules. `m_valid` stays high until the final byte is accepted. `m_data` and `m_last` hold steady while `m_ready` is low. A published message is held until it has been fully drained, and the engine does not capture a new message into the buffer while the old one is held.

Top module: `i2c_tgt_msg_framer`

## Requirements
- R1: After reset the engine is idle, `m_valid` is 0, `tx_byte` is 0xFF, all error pulses and `tx_done` are 0, and `tx_req` equals `tx_pending`.
- R2: A write-direction address event (`ev_addr`=1, `ev_rnw`=0, `ev_stop`=0) starts a message. The next data byte is stored as byte 0, the one after it as byte 1, and later data bytes are stored as payload in arrival order.
- R3: The expected length comes from byte 0 (b0) and byte 1 (b1). If b0[7]=0, the length is b1+2. If b0[7]=1, b0[6:5] selects the length: 00 gives 2, 01 gives 3, 10 gives b1+2, and 11 gives 0, so the message can never match.
- R4: At a stop event (`ev_stop`=1, `ev_addr`=0), if the captured count equals the expected length, the message is published. From the cycle after the stop, `m_data` presents the bytes in order, `m_last` marks the final byte, and the stream holds under back-pressure.
- R5: At a stop event, if the captured count differs from the expected length, the message is discarded and `err_len` pulses for one cycle.
- R6: Data bytes beyond MAX_MSG are dropped and each one pulses `err_ovf`. A message of exactly MAX_MSG bytes is accepted whole.
- R7: A read-direction address event after exactly one data byte equal to 0x01 opens a transmit phase. `tx_byte` becomes message byte 0, and each later read request drives the next byte. A read request after all `tx_len` bytes (`tx_len` >= 1) drives 0xFF, pulses `err_flags` and returns the engine to idle.
- R8: A read-direction address event after one data byte other than 0x01 pulses `err_noreadcmd`, sets `tx_byte` to 0xFF and returns the engine to idle.
- R9: If `tx_pending` is 0 when a transmit phase opens, the bytes driven are 0x02, 0x07, 0x02, and a stop after those three bytes pulses `tx_done`.
- R10: A stop in the transmit phase after all bytes pulses `tx_done`. A stop before all bytes pulses `err_tx_short`, and the next transmit phase restarts from byte 0.
- R11: An unexpected combination pulses `err_flags` and returns the engine to idle. The combinations are: address and stop together, a data byte during transmit, and a read request outside transmit (which also drives 0xFF).
- R12: A write-direction address event while a published message is still held pulses `err_overrun`. The bytes of that transaction are ignored, and the held message is delivered intact.
- R13: `tx_req` is high exactly when `tx_pending` is 1 and no transmit phase is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_stb | input | 1 | One-cycle bus event strobe |
| ev_addr | input | 1 | Event is an address match |
| ev_rnw | input | 1 | Event is in the read direction |
| ev_stop | input | 1 | Event is the end of a transaction |
| ev_byte | input | 8 | Byte received with the event |
| tx_byte | output | 8 | Byte to drive on the next read |
| tx_pending | input | 1 | An outgoing message is queued |
| tx_len | input | $clog2(MAX_MSG+1) | Byte count of the queued message, size byte included |
| tx_addr | output | $clog2(MAX_MSG) | Index into the outgoing message store |
| tx_data | input | 8 | Byte at `tx_addr`, combinational |
| tx_req | output | 1 | Transfer request toward the bus initiator |
| tx_done | output | 1 | Pulse: outgoing message fully sent |
| m_valid | output | 1 | Received-message stream valid |
| m_ready | input | 1 | Received-message stream ready |
| m_data | output | 8 | Received-message byte |
| m_last | output | 1 | Final byte of the message |
| err_len | output | 1 | Pulse: length mismatch |
| err_ovf | output | 1 | Pulse: byte dropped past the buffer size |
| err_noreadcmd | output | 1 | Pulse: read without a read command |
| err_flags | output | 1 | Pulse: unexpected event combination |
| err_overrun | output | 1 | Pulse: new write while a message is held |
| err_tx_short | output | 1 | Pulse: transmit ended early |

## Verification
The bench builds the engine with MAX_MSG set to 8. With that size, the full-buffer boundary and the overflow drops are reached within ten bytes, next to the header lengths from the decode table. The outgoing store is a four-byte bench array, which keeps the transmit order, the 0xFF past the end, and the early-stop restart short. The default of 32 bytes changes only the counter and index widths.

// File: rtl/framer_pkg.sv
package framer_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_HDR,
    ST_RXP,
    ST_TXP
  } fr_state_t;

  localparam logic [7:0] READ_CMD  = 8'h01;
  localparam logic [7:0] IDLE_BYTE = 8'hFF;
  localparam int         NOOP_LEN  = 3;

  // filler sequence 0x02 0x07 0x02
  function automatic logic [7:0] noop_byte(input logic [1:0] idx);
    return (idx == 2'd1) ? 8'h07 : 8'h02;
  endfunction
endpackage

// File: rtl/framer_lendec.sv
module framer_lendec (
  input  logic [2:0] kind,   // byte 0 bits 7:5
  input  logic [7:0] hdr_len,
  output logic [8:0] exp_len
);
  always_comb begin
    if (!kind[2]) exp_len = {1'b0, hdr_len} + 9'd2;
    else begin
      case (kind[1:0])
        2'b00:   exp_len = 9'd2;
        2'b01:   exp_len = 9'd3;
        2'b10:   exp_len = {1'b0, hdr_len} + 9'd2;
        default: exp_len = 9'd0;
      endcase
    end
  end
endmodule

// File: rtl/framer_txsel.sv
module framer_txsel
  import framer_pkg::*;
(
  input  logic       use_noop,
  input  logic [1:0] idx,
  input  logic [7:0] q_data,
  output logic [7:0] sel_byte
);
  always_comb sel_byte = use_noop ? noop_byte(idx) : q_data;
endmodule

// File: rtl/framer_rxbuf.sv
module framer_rxbuf #(
  parameter int MAX_MSG = 32,
  localparam int IW = $clog2(MAX_MSG),
  localparam int CW = $clog2(MAX_MSG + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [7:0]    wr_data,
  input  logic          pub,
  input  logic [CW-1:0] pub_len,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [7:0]    m_data,
  output logic          m_last
);
  logic [7:0]    mem [MAX_MSG];
  logic [CW-1:0] rd;
  logic [CW-1:0] len;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      rd      <= '0;
      len     <= '0;
    end else if (pub) begin
      m_valid <= 1'b1;
      rd      <= '0;
      len     <= pub_len;
    end else if (m_valid && m_ready) begin
      if (rd == len - 1'b1) m_valid <= 1'b0;
      rd <= rd + 1'b1;
    end
  end

  assign m_data = mem[rd[IW-1:0]];
  assign m_last = m_valid && (rd == len - 1'b1);

  // R4: stream holds under back-pressure
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_last));
  // R12: held message is never overwritten
  a_r12_no_write_held: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !m_valid);
  a_r12_no_pub_held: assert property (@(posedge clk) disable iff (!rst_n)
    pub |-> !m_valid);
endmodule

// File: rtl/i2c_tgt_msg_framer.sv
module i2c_tgt_msg_framer
  import framer_pkg::*;
#(
  parameter int MAX_MSG = 32,
  localparam int IW = $clog2(MAX_MSG),
  localparam int CW = $clog2(MAX_MSG + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_stb,
  input  logic          ev_addr,
  input  logic          ev_rnw,
  input  logic          ev_stop,
  input  logic [7:0]    ev_byte,
  output logic [7:0]    tx_byte,
  input  logic          tx_pending,
  input  logic [CW-1:0] tx_len,
  output logic [IW-1:0] tx_addr,
  input  logic [7:0]    tx_data,
  output logic          tx_req,
  output logic          tx_done,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [7:0]    m_data,
  output logic          m_last,
  output logic          err_len,
  output logic          err_ovf,
  output logic          err_noreadcmd,
  output logic          err_flags,
  output logic          err_overrun,
  output logic          err_tx_short
);
  fr_state_t     state;
  logic [CW-1:0] cnt, ptr, cur_len;
  logic [7:0]    b0, b1;
  logic          use_noop;

  // event decode
  logic wr_addr, rd_addr, wr_dat, rd_req, stop_ev, bad_combo;
  assign wr_addr   = ev_stb &  ev_addr & ~ev_rnw & ~ev_stop;
  assign rd_addr   = ev_stb &  ev_addr &  ev_rnw & ~ev_stop;
  assign wr_dat    = ev_stb & ~ev_addr & ~ev_rnw & ~ev_stop;
  assign rd_req    = ev_stb & ~ev_addr &  ev_rnw & ~ev_stop;
  assign stop_ev   = ev_stb & ~ev_addr &  ev_stop;
  assign bad_combo = ev_stb &  ev_addr &  ev_stop;

  logic [8:0] exp_len;
  framer_lendec u_lendec (
    .kind    (b0[7:5]),
    .hdr_len (b1),
    .exp_len (exp_len)
  );

  logic       in_tx;
  logic       sel_noop;
  logic [7:0] sel_byte;
  assign in_tx    = (state == ST_TXP);
  assign sel_noop = in_tx ? use_noop : ~tx_pending;
  assign tx_addr  = in_tx ? ptr[IW-1:0] : '0;

  framer_txsel u_txsel (
    .use_noop (sel_noop),
    .idx      (in_tx ? ptr[1:0] : 2'd0),
    .q_data   (tx_data),
    .sel_byte (sel_byte)
  );

  logic          buf_we, pub, len_ok, held;
  logic [IW-1:0] buf_idx;
  assign held    = m_valid;
  assign buf_idx = cnt[IW-1:0];
  assign buf_we  = wr_dat && ((state == ST_ADDR) || (state == ST_HDR) ||
                              ((state == ST_RXP) && (int'(cnt) < MAX_MSG)));
  assign len_ok  = (int'(cnt) == int'(exp_len));
  assign pub     = stop_ev && (state == ST_RXP) && len_ok;

  framer_rxbuf #(.MAX_MSG(MAX_MSG)) u_rxbuf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (buf_we),
    .wr_idx  (buf_idx),
    .wr_data (ev_byte),
    .pub     (pub),
    .pub_len (cnt),
    .m_valid (m_valid),
    .m_ready (m_ready),
    .m_data  (m_data),
    .m_last  (m_last)
  );

  assign tx_req = tx_pending && !in_tx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= ST_IDLE;
      cnt           <= '0;
      ptr           <= '0;
      cur_len       <= '0;
      b0            <= '0;
      b1            <= '0;
      use_noop      <= 1'b0;
      tx_byte       <= IDLE_BYTE;
      tx_done       <= 1'b0;
      err_len       <= 1'b0;
      err_ovf       <= 1'b0;
      err_noreadcmd <= 1'b0;
      err_flags     <= 1'b0;
      err_overrun   <= 1'b0;
      err_tx_short  <= 1'b0;
    end else begin
      tx_done       <= 1'b0;
      err_len       <= 1'b0;
      err_ovf       <= 1'b0;
      err_noreadcmd <= 1'b0;
      err_flags     <= 1'b0;
      err_overrun   <= 1'b0;
      err_tx_short  <= 1'b0;
      if (bad_combo) begin
        err_flags <= 1'b1;
        state     <= ST_IDLE;
      end else if (wr_addr) begin
        cnt <= '0;
        if (held) begin
          err_overrun <= 1'b1;
          state       <= ST_IDLE;
        end else begin
          state <= ST_ADDR;
        end
      end else if (rd_addr) begin
        if (state == ST_HDR && b0 == READ_CMD) begin
          state    <= ST_TXP;
          use_noop <= ~tx_pending;
          cur_len  <= tx_pending ? tx_len : CW'(NOOP_LEN);
          tx_byte  <= sel_byte;
          ptr      <= CW'(1);
        end else begin
          tx_byte <= IDLE_BYTE;
          state   <= ST_IDLE;
          if (state == ST_HDR) err_noreadcmd <= 1'b1;
          else                 err_flags     <= 1'b1;
        end
      end else if (wr_dat) begin
        case (state)
          ST_ADDR: begin
            b0    <= ev_byte;
            cnt   <= CW'(1);
            state <= ST_HDR;
          end
          ST_HDR: begin
            b1    <= ev_byte;
            cnt   <= CW'(2);
            state <= ST_RXP;
          end
          ST_RXP: begin
            if (int'(cnt) < MAX_MSG) cnt <= cnt + 1'b1;
            else                     err_ovf <= 1'b1;
          end
          ST_TXP: begin
            err_flags <= 1'b1;
            state     <= ST_IDLE;
          end
          default: ;
        endcase
      end else if (rd_req) begin
        if (in_tx && ptr < cur_len) begin
          tx_byte <= sel_byte;
          ptr     <= ptr + 1'b1;
        end else begin
          tx_byte   <= IDLE_BYTE;
          err_flags <= 1'b1;
          state     <= ST_IDLE;
        end
      end else if (stop_ev) begin
        case (state)
          ST_TXP: begin
            if (ptr == cur_len) tx_done      <= 1'b1;
            else                err_tx_short <= 1'b1;
          end
          ST_RXP:           if (!len_ok) err_len <= 1'b1;
          ST_ADDR, ST_HDR:  err_flags <= 1'b1;
          default: ;
        endcase
        state <= ST_IDLE;
      end
    end
  end

  // R11: at most one fault or completion pulse per cycle
  a_r11_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_len, err_ovf, err_noreadcmd, err_flags, err_overrun, err_tx_short, tx_done}));
  // R10: completion only follows a transmit phase
  a_r10_done_from_tx: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> $past(state) == ST_TXP);
  // R6: capture count stays within the buffer
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) <= MAX_MSG);
  // R12: overrun only while a message was held
  a_r12_overrun_held: assert property (@(posedge clk) disable iff (!rst_n)
    err_overrun |-> $past(m_valid));
  // R7: read pointer never passes the message length
  a_r7_ptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
    in_tx && cur_len != '0 |-> ptr <= cur_len);
endmodule

// File: tb/i2c_tgt_msg_framer_bench.sv
module i2c_tgt_msg_framer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MAXM = 8;
  localparam int IW = $clog2(MAXM);
  localparam int CW = $clog2(MAXM + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_stb = 0, ev_addr = 0, ev_rnw = 0, ev_stop = 0;
  logic [7:0] ev_byte = 0;
  logic [7:0] tx_byte;
  logic tx_pending = 0;
  logic [CW-1:0] tx_len = CW'(4);
  logic [IW-1:0] tx_addr;
  logic [7:0] tx_data;
  logic tx_req, tx_done, m_valid, m_ready = 0, m_last;
  logic [7:0] m_data;
  logic err_len, err_ovf, err_noreadcmd, err_flags, err_overrun, err_tx_short;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [7:0] tx_mem [4] = '{8'h04, 8'hA1, 8'hA2, 8'hA3};
  assign tx_data = (int'(tx_addr) < 4) ? tx_mem[tx_addr[1:0]] : 8'h00;

  i2c_tgt_msg_framer #(.MAX_MSG(MAXM)) u_i2c_tgt_msg_framer (
    .clk(clk), .rst_n(rst_n), .ev_stb(ev_stb), .ev_addr(ev_addr), .ev_rnw(ev_rnw),
    .ev_stop(ev_stop), .ev_byte(ev_byte), .tx_byte(tx_byte), .tx_pending(tx_pending),
    .tx_len(tx_len), .tx_addr(tx_addr), .tx_data(tx_data), .tx_req(tx_req),
    .tx_done(tx_done), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .m_last(m_last), .err_len(err_len), .err_ovf(err_ovf), .err_noreadcmd(err_noreadcmd),
    .err_flags(err_flags), .err_overrun(err_overrun), .err_tx_short(err_tx_short)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic ev(input logic a, input logic r, input logic s, input logic [7:0] b);
    @(negedge clk);
    ev_stb = 1; ev_addr = a; ev_rnw = r; ev_stop = s; ev_byte = b;
    @(negedge clk);
    ev_stb = 0; ev_addr = 0; ev_rnw = 0; ev_stop = 0;
  endtask

  // write transaction: address, bytes, optional stop
  logic [7:0] msg [12];
  task automatic wr_msg(input int n, input bit with_stop);
    ev(1, 0, 0, 8'h52);
    for (int i = 0; i < n; i++) ev(0, 0, 0, msg[i]);
    if (with_stop) ev(0, 0, 1, 8'h00);
  endtask

  task automatic drain(input int n, input string tag);
    m_ready = 1;
    for (int i = 0; i < n; i++) begin
      chk(m_valid && m_data == msg[i] && m_last == (i == n-1), tag, m_data, msg[i]);
      @(negedge clk);
    end
    m_ready = 0;
    chk(!m_valid, tag, m_valid, 0);
  endtask

  task automatic fill(input logic [7:0] b0, input logic [7:0] b1, input int n);
    msg[0] = b0; msg[1] = b1;
    for (int i = 2; i < 12; i++) msg[i] = 8'h30 + 8'(i);
    if (n < 0) msg[0] = b0;
  endtask

  // vector table: kind byte, length byte, bytes sent, accepted
  typedef struct packed { logic [7:0] b0; logic [7:0] b1; logic [7:0] n; logic ok; } vec_t;
  localparam vec_t VECS [9] = '{
    '{8'h00, 8'h03, 8'd5, 1'b1},
    '{8'h00, 8'h03, 8'd4, 1'b0},
    '{8'h80, 8'h11, 8'd2, 1'b1},
    '{8'hA0, 8'h00, 8'd3, 1'b1},
    '{8'hA0, 8'h00, 8'd4, 1'b0},
    '{8'hC0, 8'h02, 8'd4, 1'b1},
    '{8'hE0, 8'h00, 8'd2, 1'b0},
    '{8'h05, 8'h00, 8'd2, 1'b1},
    '{8'h85, 8'h09, 8'd2, 1'b1}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!m_valid && tx_byte == 8'hFF && !tx_req && !err_flags && !tx_done, "R1 reset", tx_byte, 8'hFF);
    rst_n = 1;
    @(negedge clk);
    chk(tx_byte == 8'hFF && !m_valid, "R1 after release", tx_byte, 8'hFF);

    // R2 R3 R4 R5 table walk
    foreach (VECS[k]) begin
      fill(VECS[k].b0, VECS[k].b1, 0);
      wr_msg(int'(VECS[k].n), 1);
      if (VECS[k].ok) begin
        chk(!err_len && m_valid, "R3 R4 accepted", m_valid, 1);
        drain(int'(VECS[k].n), "R2 R4 stream");
      end else begin
        chk(err_len && !m_valid, "R3 R5 rejected", err_len, 1);
      end
    end

    // R4 back-pressure
    fill(8'h00, 8'h01, 0);
    wr_msg(3, 1);
    repeat (3) @(negedge clk);
    chk(m_valid && m_data == 8'h00 && !m_last, "R4 held", m_data, 0);
    drain(3, "R4 drain");

    // R6 exactly MAX accepted
    fill(8'h00, 8'h06, 0);
    wr_msg(8, 1);
    chk(m_valid && !err_len, "R6 full size", m_valid, 1);
    drain(8, "R6 full stream");
    // R6 overflow
    fill(8'h00, 8'h08, 0);
    wr_msg(8, 0);
    ev(0, 0, 0, 8'h99);
    chk(err_ovf == 1'b1, "R6 overflow", err_ovf, 1);
    ev(0, 0, 0, 8'h9A);
    chk(err_ovf == 1'b1, "R6 overflow 2", err_ovf, 1);
    ev(0, 0, 1, 8'h00);
    chk(err_len && !m_valid, "R6 overflow discard", err_len, 1);

    // R12 overrun
    fill(8'h80, 8'h00, 0);
    wr_msg(2, 1);
    ev(1, 0, 0, 8'h52);
    chk(err_overrun == 1'b1, "R12 overrun", err_overrun, 1);
    ev(0, 0, 0, 8'h00); ev(0, 0, 0, 8'h05); ev(0, 0, 1, 8'h00);
    chk(!err_len && m_valid, "R12 ignored", err_len, 0);
    drain(2, "R12 intact");

    // R7 R13 transmit queued message
    tx_pending = 1;
    @(negedge clk);
    chk(tx_req == 1'b1, "R13 request idle", tx_req, 1);
    msg[0] = 8'h01;
    wr_msg(1, 0);
    ev(1, 1, 0, 8'h53);
    chk(tx_byte == 8'h04, "R7 first byte", tx_byte, 8'h04);
    chk(tx_req == 1'b0, "R13 no request in tx", tx_req, 0);
    for (int i = 1; i < 4; i++) begin
      ev(0, 1, 0, 8'h00);
      chk(tx_byte == tx_mem[i], "R7 next byte", tx_byte, tx_mem[i]);
    end
    ev(0, 1, 0, 8'h00);
    chk(tx_byte == 8'hFF && err_flags, "R7 past end", tx_byte, 8'hFF);

    // R10 complete
    wr_msg(1, 0);
    ev(1, 1, 0, 8'h53);
    for (int i = 1; i < 4; i++) ev(0, 1, 0, 8'h00);
    ev(0, 1, 1, 8'h00);
    chk(tx_done == 1'b1, "R10 done", tx_done, 1);
    // R10 short then restart
    wr_msg(1, 0);
    ev(1, 1, 0, 8'h53);
    ev(0, 1, 0, 8'h00);
    ev(0, 1, 1, 8'h00);
    chk(err_tx_short && !tx_done, "R10 short", err_tx_short, 1);
    chk(tx_req == 1'b1, "R13 request again", tx_req, 1);
    wr_msg(1, 0);
    ev(1, 1, 0, 8'h53);
    chk(tx_byte == 8'h04, "R10 restart at 0", tx_byte, 8'h04);
    ev(0, 1, 1, 8'h00);

    // R9 filler
    tx_pending = 0;
    wr_msg(1, 0);
    ev(1, 1, 0, 8'h53);
    chk(tx_byte == 8'h02, "R9 filler 0", tx_byte, 8'h02);
    ev(0, 1, 0, 8'h00);
    chk(tx_byte == 8'h07, "R9 filler 1", tx_byte, 8'h07);
    ev(0, 1, 0, 8'h00);
    chk(tx_byte == 8'h02, "R9 filler 2", tx_byte, 8'h02);
    ev(0, 1, 1, 8'h00);
    chk(tx_done == 1'b1, "R9 filler done", tx_done, 1);

    // R8 read without command
    msg[0] = 8'h05;
    wr_msg(1, 0);
    ev(1, 1, 0, 8'h53);
    chk(err_noreadcmd && tx_byte == 8'hFF, "R8 no read cmd", tx_byte, 8'hFF);

    // R11 unexpected combinations
    ev(1, 0, 1, 8'h00);
    chk(err_flags == 1'b1, "R11 addr+stop", err_flags, 1);
    msg[0] = 8'h01;
    wr_msg(1, 0);
    ev(1, 1, 0, 8'h53);
    ev(0, 0, 0, 8'h44);
    chk(err_flags == 1'b1, "R11 data in tx", err_flags, 1);
    ev(0, 1, 0, 8'h00);
    chk(err_flags && tx_byte == 8'hFF, "R11 read outside tx", tx_byte, 8'hFF);
    // engine still usable
    fill(8'h80, 8'h00, 0);
    wr_msg(2, 1);
    chk(m_valid == 1'b1, "R11 recovers", m_valid, 1);
    drain(2, "R11 recover stream");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule